// File: doc/BRIEF.md
# Alternating Read/Write Burst Scheduler

This block is a small memory core with two independent ports, one for reads and one for writes. Each port has its own active-low select, sampled on the rising clock edge. Every transaction moves a burst of four words and occupies two clock cycles, two words per cycle. Because the core accepts at most one new transaction per edge, an arbiter chooses between the two ports when both are selected. The choice depends on which kind of transaction started on the previous edge, so a steady request on both ports produces alternating read and write bursts.

A write presents words 0 and 1 on the edge where it starts and words 2 and 3 on the following edge. A read captures its burst on its start edge. After a fixed, parameterised latency it returns the burst as two beats with a valid flag. A read that starts one edge after a write to the same burst sees the words still arriving on the write port. Addresses select a whole burst: the two low word-address bits are implicitly zero, so word `i` of burst `a` lives at word address `4*a + i`.

Top module: `burst_sched`

## Requirements
- R1: A transaction starts on a rising edge only when its port's select is low at that edge. `rd_start` and `wr_start` show, in the cycle before the edge, which one will start, and they are never high together.
- R2: With both selects low and nothing started on the previous edge, the read starts.
- R3: If a read started on the previous edge, a read cannot start. With both selects low, the write starts.
- R4: If a write started on the previous edge, a write cannot start. With both selects low, the read starts.
- R5: Holding both selects low from idle starts read, write, read, write, and so on.
- R6: A write places `wr_data[DW-1:0]` in word 0 and `wr_data[2*DW-1:DW]` in word 1 at its start edge. On the next edge it places them in words 2 and 3.
- R7: For a read starting at edge S, `rd_valid` is high after edge S+RD_LAT-1 with words 1:0 on `rd_data` (word 0 in the low half), and after edge S+RD_LAT with words 3:2. At all other times `rd_valid` is low.
- R8: A read starting one edge after a write to the same burst returns the words the write delivers on that edge.
- R9: A refused select is dropped and not queued. It starts nothing later unless it is still low at a later edge.
- R10: A started burst completes even if its select is released. Releasing one port's select does not affect the other port.
- R11: After reset, no transaction is remembered, `rd_valid` is low and every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Read port select, active low |
| rd_addr | input | BAW | Burst address for a read |
| wr_sel_n | input | 1 | Write port select, active low |
| wr_addr | input | BAW | Burst address for a write |
| wr_data | input | 2*DW | Two write words per cycle, lower word in low half |
| rd_start | output | 1 | A read starts on the coming edge |
| wr_start | output | 1 | A write starts on the coming edge |
| rd_data | output | 2*DW | Two read words per beat, zero when not valid |
| rd_valid | output | 1 | `rd_data` carries a read beat |

## Verification
The assertions assume that the selects change only away from the rising edge, and that the checker's own record of the previous start agrees with the core after reset. They also assume that a refused port will simply retry, so no request is ever pending. The stimulus changes all inputs on the falling edge and idles the ports between directed sequences, so every arbitration case begins from a known previous start. Write data for words 2 and 3 is driven on the cycle after the start, whatever the write select does.

// File: rtl/burst_sched.sv
module burst_sched #(
  parameter int DW     = 16,
  parameter int BAW    = 4,
  parameter int RD_LAT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_sel_n,
  input  logic [BAW-1:0]  rd_addr,
  input  logic            wr_sel_n,
  input  logic [BAW-1:0]  wr_addr,
  input  logic [2*DW-1:0] wr_data,
  output logic            rd_start,
  output logic            wr_start,
  output logic [2*DW-1:0] rd_data,
  output logic            rd_valid
);
  localparam int WORDS = 4 << BAW;
  localparam int LAST  = RD_LAT - 1;

  logic [DW-1:0]   mem [WORDS];
  logic            last_rd, last_wr;
  logic [BAW-1:0]  tail_addr;
  logic            fwd;
  logic [4*DW-1:0] rd_burst;
  logic [4*DW-1:0] pipe_d [RD_LAT];
  logic [RD_LAT-1:0] pipe_v;
  logic            hi_v;
  logic [2*DW-1:0] hi_d;

  assign rd_start = ~rd_sel_n & ~last_rd;
  assign wr_start = ~wr_sel_n & ~last_wr & ~rd_start;

  assign fwd      = last_wr && (tail_addr == rd_addr);
  assign rd_burst = {fwd ? wr_data : {mem[{rd_addr, 2'd3}], mem[{rd_addr, 2'd2}]},
                     mem[{rd_addr, 2'd1}], mem[{rd_addr, 2'd0}]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_rd   <= 1'b0;
      last_wr   <= 1'b0;
      tail_addr <= '0;
    end else begin
      last_rd <= rd_start;
      last_wr <= wr_start;
      if (wr_start) tail_addr <= wr_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      if (wr_start) begin
        mem[{wr_addr, 2'd0}] <= wr_data[DW-1:0];
        mem[{wr_addr, 2'd1}] <= wr_data[2*DW-1:DW];
      end
      if (last_wr) begin
        mem[{tail_addr, 2'd2}] <= wr_data[DW-1:0];
        mem[{tail_addr, 2'd3}] <= wr_data[2*DW-1:DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_v <= '0;
      hi_v   <= 1'b0;
    end else begin
      pipe_v[0] <= rd_start;
      for (int k = 1; k < RD_LAT; k++) pipe_v[k] <= pipe_v[k-1];
      hi_v <= pipe_v[LAST];
    end
  end

  always_ff @(posedge clk) begin
    pipe_d[0] <= rd_burst;
    for (int k = 1; k < RD_LAT; k++) pipe_d[k] <= pipe_d[k-1];
    hi_d <= pipe_d[LAST][4*DW-1:2*DW];
  end

  assign rd_valid = pipe_v[LAST] | hi_v;
  assign rd_data  = pipe_v[LAST] ? pipe_d[LAST][2*DW-1:0] : (hi_v ? hi_d : '0);
endmodule

// File: rtl/burst_sched_chk.sv
module burst_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_sel_n,
  input logic wr_sel_n,
  input logic rd_start,
  input logic wr_start
);
  logic prev_r, prev_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_r <= 1'b0;
      prev_w <= 1'b0;
    end else begin
      prev_r <= rd_start;
      prev_w <= wr_start;
    end
  end

  // R1
  one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_start && wr_start));

  // R1
  start_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start |-> !rd_sel_n) and (wr_start |-> !wr_sel_n));

  // R2
  idle_read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel_n && !wr_sel_n && !prev_r && !prev_w) |-> rd_start);

  // R3
  no_read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !rd_start);

  // R3
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_r && !wr_sel_n) |-> wr_start);

  // R4
  no_write_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);

  // R4
  read_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_w && !rd_sel_n) |-> rd_start);
endmodule

bind burst_sched burst_sched_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
  .rd_start(rd_start), .wr_start(wr_start)
);

// File: tb/burst_sched_tb_top.sv
module burst_sched_tb_top;
  localparam int CLK_P  = 10;
  localparam int DW     = 16;
  localparam int BAW    = 4;
  localparam int RD_LAT = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [BAW-1:0]  rd_addr = '0, wr_addr = '0;
  logic [2*DW-1:0] wr_data = '0;
  logic            rd_start, wr_start, rd_valid;
  logic [2*DW-1:0] rd_data;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  string cur_req = "R11";

  logic [4*DW-1:0] ref_mem [1<<BAW];
  logic [2*DW-1:0] exp_beat [int];
  bit              tail_pend = 1'b0;
  logic [BAW-1:0]  tail_a;

  always #(CLK_P/2) clk = ~clk;

  burst_sched #(.DW(DW), .BAW(BAW), .RD_LAT(RD_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .rd_addr(rd_addr),
    .wr_sel_n(wr_sel_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_start(rd_start), .wr_start(wr_start), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference: all four words of a burst become visible by the edge after the write starts.
  always @(posedge clk) if (rst_n) begin
    cyc++;
    if (tail_pend) begin
      ref_mem[tail_a][4*DW-1:2*DW] = wr_data;
      tail_pend = 1'b0;
    end
    if (wr_start) begin
      ref_mem[wr_addr][2*DW-1:0] = wr_data;
      tail_pend = 1'b1;
      tail_a = wr_addr;
    end
    if (rd_start) begin
      exp_beat[cyc+RD_LAT-1] = ref_mem[rd_addr][2*DW-1:0];
      exp_beat[cyc+RD_LAT]   = ref_mem[rd_addr][4*DW-1:2*DW];
    end
  end

  // R7 timing and data of every read beat
  always @(negedge clk) if (rst_n) begin
    if (exp_beat.exists(cyc)) begin
      check(rd_valid && rd_data == exp_beat[cyc], cur_req, {31'd0, rd_valid, rd_data}, {32'd1, exp_beat[cyc]});
      exp_beat.delete(cyc);
    end else if (rd_valid) begin
      check(1'b0, "R7", {31'd0, rd_valid, rd_data}, 64'd0);
    end
  end

  task automatic step(input logic rs_n, input logic [BAW-1:0] ra, input logic ws_n,
                      input logic [BAW-1:0] wa, input logic [2*DW-1:0] wd,
                      input logic er, input logic ew, input string req);
    @(negedge clk);
    rd_sel_n = rs_n; rd_addr = ra; wr_sel_n = ws_n; wr_addr = wa; wr_data = wd;
    #1;
    check(rd_start == er && wr_start == ew, req, {rd_start, wr_start}, {er, ew});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, '0, 1'b1, '0, '0, 1'b0, 1'b0, "R1");
  endtask

  // {rd_sel_n, wr_sel_n, expected rd_start, expected wr_start, requirement number}
  localparam logic [7:0] VEC [16] = '{
    {4'b1100, 4'd1}, {4'b0010, 4'd2}, {4'b0001, 4'd3}, {4'b0010, 4'd4},
    {4'b0001, 4'd5}, {4'b1100, 4'd1}, {4'b0110, 4'd1}, {4'b0100, 4'd9},
    {4'b0110, 4'd9}, {4'b1001, 4'd3}, {4'b1000, 4'd4}, {4'b1001, 4'd9},
    {4'b1100, 4'd1}, {4'b1001, 4'd1}, {4'b0010, 4'd4}, {4'b1100, 4'd1}
  };

  initial begin
    for (int i = 0; i < (1 << BAW); i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state and zero contents
    #1;
    check(!rd_valid && !rd_start && !wr_start, "R11", {rd_valid, rd_start, wr_start}, 3'b000);
    check(rd_data == '0, "R11", rd_data, '0);
    cur_req = "R11";
    step(1'b0, 4'd5, 1'b1, '0, '0, 1'b1, 1'b0, "R11");
    idle(4);

    // Arbitration table (R2, R3, R4, R5, R9); writes carry zero data to burst 0
    cur_req = "R5";
    for (int v = 0; v < 16; v++)
      step(VEC[v][7], '0, VEC[v][6], '0, '0, VEC[v][5], VEC[v][4], $sformatf("R%0d", VEC[v][3:0]));
    idle(4);

    // R6, R7: write burst 3, read it back
    cur_req = "R6";
    step(1'b1, '0, 1'b0, 4'd3, 32'h1111_0000, 1'b0, 1'b1, "R6");
    step(1'b1, '0, 1'b1, '0, 32'h3333_2222, 1'b0, 1'b0, "R6");
    idle(1);
    cur_req = "R7";
    step(1'b0, 4'd3, 1'b1, '0, '0, 1'b1, 1'b0, "R7");
    idle(4);

    // R8: read of burst 7 on the edge after its write starts
    cur_req = "R8";
    step(1'b1, '0, 1'b0, 4'd7, 32'hA1A1_A0A0, 1'b0, 1'b1, "R8");
    step(1'b0, 4'd7, 1'b1, '0, 32'hA3A3_A2A2, 1'b1, 1'b0, "R8");
    idle(4);

    // R10: read released after start; write to burst 9 started beside it and released
    cur_req = "R10";
    step(1'b0, 4'd3, 1'b1, '0, '0, 1'b1, 1'b0, "R10");
    step(1'b1, '0, 1'b0, 4'd9, 32'hB1B1_B0B0, 1'b0, 1'b1, "R10");
    step(1'b1, '0, 1'b1, '0, 32'hB3B3_B2B2, 1'b0, 1'b0, "R10");
    idle(1);
    step(1'b0, 4'd9, 1'b1, '0, '0, 1'b1, 1'b0, "R10");
    idle(4);

    // R9: refused read dropped, no later beats beyond the first burst
    cur_req = "R9";
    step(1'b0, 4'd7, 1'b1, '0, '0, 1'b1, 1'b0, "R9");
    step(1'b0, 4'd3, 1'b1, '0, '0, 1'b0, 1'b0, "R9");
    idle(5);

    // R4/R8: overwrite burst 7, alternating with both selects held
    cur_req = "R8";
    step(1'b1, '0, 1'b0, 4'd7, 32'hC1C1_C0C0, 1'b0, 1'b1, "R8");
    step(1'b0, 4'd7, 1'b0, 4'd2, 32'hC3C3_C2C2, 1'b1, 1'b0, "R4");
    step(1'b0, 4'd7, 1'b0, 4'd2, 32'h5151_5050, 1'b0, 1'b1, "R3");
    step(1'b1, '0, 1'b1, '0, 32'h5353_5252, 1'b0, 1'b0, "R6");
    step(1'b0, 4'd2, 1'b1, '0, '0, 1'b1, 1'b0, "R6");
    idle(5);

    check(exp_beat.num() == 0, "R7", exp_beat.num(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule